// File: doc/BRIEF.md
# Banked SDRAM Command Scheduler

This block turns single read and write requests into a legal stream of commands for a synchronous DRAM with several independent banks. Each request names a bank, a row and a column, and it can ask for the bank to close itself after the access. The scheduler keeps an open/closed flag, the open row and a set of cycle timers for every bank. From these it decides, one command per clock, whether the buffered request can take its column access now, must first close a bank holding a different row, or must open its row.

A free-running interval counter raises a refresh demand. While that demand is pending, new request commands are held back. Open banks are closed, the lowest bank index first. Once every bank is closed and its precharge time has run out, the refresh command goes out. A row may then be opened again only after the refresh cycle time has passed. Timers belong to single banks, so work on one bank never waits for the timers of another. Requests enter through a valid/ready handshake into a one-entry slot.

Top module: `sdram_cmd_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, cmd_valid is 0, req_ready is 1 and every bank counts as closed.
- R2: req_ready is 1 when the request slot is empty, or when the buffered request's column command goes out in that same cycle, and is 0 otherwise. A request is taken on a clock edge where req_valid and req_ready are both 1.
- R3: A request to a closed bank produces ACTIVE (code 1) with the row on cmd_addr. It is issued only after T_RP cycles from that bank's last close, T_RC (default 11) cycles from that bank's previous ACTIVE, and T_RFC cycles from the last REFRESH.
- R4: A request whose row is open in its bank produces READ (code 2) or WRITE (code 3) with the column zero-extended on cmd_addr, no earlier than T_RCD (default 3) cycles after that bank's ACTIVE. Row hits need no new ACTIVE and may issue on consecutive cycles.
- R5: A request to a bank holding a different row first gets PRECHARGE (code 4) to that bank, no earlier than T_RCD cycles after its ACTIVE. An ACTIVE follows once R3 allows it.
- R6: A column command carrying cmd_autopre=1 closes its bank. The next access to that bank needs an ACTIVE no earlier than T_RP (default 3) cycles later.
- R7: A refresh demand is raised every REF_INTERVAL cycles and stays set until REFRESH (code 5) is issued. While it is set no request command is issued, and open banks receive PRECHARGE, lowest index first. REFRESH is issued only when all banks are closed, their T_RP has passed, and T_RFC has passed since the previous REFRESH.
- R8: At most one command is driven per cycle. cmd_valid is 1 exactly when cmd_kind is nonzero, and code 0 means no command.
- R9: Timers are kept per bank. An ACTIVE or column command to one bank is never delayed by another bank's T_RCD, T_RP or T_RC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The slot can take a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_autopre | input | 1 | Close the bank after this access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| cmd_valid | output | 1 | A command is driven this cycle |
| cmd_kind | output | 3 | 0 none, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH |
| cmd_bank | output | 2 | Bank addressed by the command |
| cmd_addr | output | 13 | Row for ACTIVE, column for READ/WRITE, else 0 |
| cmd_autopre | output | 1 | Auto-precharge flag on READ/WRITE |

## Verification
A wrong open-row record or a stale bank timer shows up at the ports as a command that comes one or more cycles early or late, or as an ACTIVE that is missing or extra. In the worst case it becomes a column command to the wrong row. Any of these appears on the first cycle in which the affected bank is next addressed. The refresh path shows its faults when the demand is next raised: a refresh issued with a bank still open, a precharge sent in the wrong bank order, or an ACTIVE that comes back too soon. For this reason every cycle's command and ready value are compared against a cycle-accurate behavioural model, over directed hit, miss and conflict sequences and a long pseudo-random mix that crosses several refresh intervals.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  function automatic int max_of3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sched_bank_state.sv
`timescale 1ns/1ps
module sched_bank_state #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             col_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_done_o,
  output logic             act_ok_o,
  output logic             idle_o
);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, rcd_d;
  logic [CNT_W-1:0] rp_q, rp_d;
  logic [CNT_W-1:0] rc_q, rc_d;
  logic             closing;

  assign closing = pre_i || (col_i && ap_i);

  always_comb begin
    open_d = open_q;
    if (act_i)        open_d = 1'b1;
    else if (closing) open_d = 1'b0;

    rcd_d = (rcd_q != '0) ? rcd_q - 1'b1 : rcd_q;
    if (act_i) rcd_d = CNT_W'(T_RCD - 1);

    rc_d = (rc_q != '0) ? rc_q - 1'b1 : rc_q;
    if (act_i) rc_d = CNT_W'(T_RC - 1);

    rp_d = (rp_q != '0) ? rp_q - 1'b1 : rp_q;
    if (closing) rp_d = CNT_W'(T_RP - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      rp_q   <= '0;
      rc_q   <= '0;
    end else begin
      open_q <= open_d;
      rcd_q  <= rcd_d;
      rp_q   <= rp_d;
      rc_q   <= rc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act_i) row_q <= row_i;
  end

  assign open_o     = open_q;
  assign row_o      = row_q;
  assign rcd_done_o = open_q && (rcd_q == '0);
  assign act_ok_o   = !open_q && (rp_q == '0) && (rc_q == '0);
  assign idle_o     = !open_q && (rp_q == '0);

  AST_COL_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> open_q); // R4
  AST_ACT_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_q); // R3
  AST_PRE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |-> open_q); // R5
  AST_AP_CLOSES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (col_i && ap_i) |=> !open_o); // R6
  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RC > 1 && act_i) |=> !act_i); // R3

endmodule

// File: rtl/sched_refresh.sv
`timescale 1ns/1ps
module sched_refresh #(
  parameter int REF_INTERVAL = 1560,
  parameter int T_RFC        = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_issue_i,
  output logic pending_o,
  output logic rfc_done_o
);

  localparam int IW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
  localparam int FW = $clog2(T_RFC + 1);

  logic [IW-1:0] ival_q, ival_d;
  logic [FW-1:0] rfc_q, rfc_d;
  logic          pend_q, pend_d;
  logic          due;

  assign due = (ival_q == IW'(REF_INTERVAL - 1));

  always_comb begin
    ival_d = due ? '0 : ival_q + 1'b1;
    pend_d = pend_q;
    if (ref_issue_i) pend_d = 1'b0;
    if (due)         pend_d = 1'b1;
    rfc_d = (rfc_q != '0) ? rfc_q - 1'b1 : rfc_q;
    if (ref_issue_i) rfc_d = FW'(T_RFC - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
      rfc_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ival_q <= ival_d;
      rfc_q  <= rfc_d;
      pend_q <= pend_d;
    end
  end

  assign pending_o  = pend_q;
  assign rfc_done_o = (rfc_q == '0);

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ref_issue_i) |=> pending_o); // R7
  AST_REF_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue_i |-> pend_q); // R7

endmodule

// File: rtl/sched_req_slot.sv
`timescale 1ns/1ps
module sched_req_slot #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              release_i,
  input  logic              wr_i,
  input  logic              ap_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              full_o,
  output logic              wr_o,
  output logic              ap_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);

  logic full_q, full_d;

  always_comb begin
    full_d = full_q;
    if (release_i) full_d = 1'b0;
    if (load_i)    full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      wr_o   <= wr_i;
      ap_o   <= ap_i;
      bank_o <= bank_i;
      row_o  <= row_i;
      col_o  <= col_i;
    end
  end

  assign full_o = full_q;

  AST_NO_LOAD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!full_q || release_i)); // R2
  AST_RELEASE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> full_q); // R2

endmodule

// File: rtl/sdram_cmd_sched.sv
`timescale 1ns/1ps
module sdram_cmd_sched
  import sched_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RC         = 11,
  parameter int T_RFC        = 10,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic                         req_autopre,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [COL_W-1:0]             req_col,
  output logic                         cmd_valid,
  output logic [2:0]                   cmd_kind,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [ROW_W-1:0]             cmd_addr,
  output logic                         cmd_autopre
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int T_MAX  = max_of3(T_RCD, T_RP, T_RC);
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic [NUM_BANKS-1:0] bank_open, bank_rcd_done, bank_act_ok, bank_idle;
  logic [NUM_BANKS-1:0] act_v, col_v, pre_v;
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];

  logic              buf_full, buf_wr, buf_ap;
  logic [BANK_W-1:0] buf_bank;
  logic [ROW_W-1:0]  buf_row;
  logic [COL_W-1:0]  buf_col;

  logic ref_pending, rfc_done, all_idle;
  logic pre_hit;
  logic [BANK_W-1:0] pre_sel;

  cmd_e              sel_kind;
  logic [BANK_W-1:0] sel_bank;
  logic [ROW_W-1:0]  sel_addr;
  logic              sel_ap;
  logic              col_fire, accept;

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign act_v[gb] = (sel_kind == CMD_ACT) && (sel_bank == BANK_W'(gb));
      assign pre_v[gb] = (sel_kind == CMD_PRE) && (sel_bank == BANK_W'(gb));
      assign col_v[gb] = col_fire && (sel_bank == BANK_W'(gb));

      sched_bank_state #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W),
        .T_RCD (T_RCD),
        .T_RP  (T_RP),
        .T_RC  (T_RC)
      ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act_v[gb]),
        .col_i      (col_v[gb]),
        .ap_i       (sel_ap),
        .pre_i      (pre_v[gb]),
        .row_i      (sel_addr),
        .open_o     (bank_open[gb]),
        .row_o      (bank_row[gb]),
        .rcd_done_o (bank_rcd_done[gb]),
        .act_ok_o   (bank_act_ok[gb]),
        .idle_o     (bank_idle[gb])
      );
    end
  endgenerate

  sched_refresh #(
    .REF_INTERVAL (REF_INTERVAL),
    .T_RFC        (T_RFC)
  ) u_refresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_issue_i (sel_kind == CMD_REF),
    .pending_o   (ref_pending),
    .rfc_done_o  (rfc_done)
  );

  assign col_fire  = (sel_kind == CMD_RD) || (sel_kind == CMD_WR);
  assign req_ready = !buf_full || col_fire;
  assign accept    = req_valid && req_ready;

  sched_req_slot #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept),
    .release_i (col_fire),
    .wr_i      (req_write),
    .ap_i      (req_autopre),
    .bank_i    (req_bank),
    .row_i     (req_row),
    .col_i     (req_col),
    .full_o    (buf_full),
    .wr_o      (buf_wr),
    .ap_o      (buf_ap),
    .bank_o    (buf_bank),
    .row_o     (buf_row),
    .col_o     (buf_col)
  );

  assign all_idle = &bank_idle;

  // Lowest-index open bank whose activate-to-column time has passed.
  always_comb begin
    pre_hit = 1'b0;
    pre_sel = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bank_open[b] && bank_rcd_done[b]) begin
        pre_hit = 1'b1;
        pre_sel = BANK_W'(b);
      end
    end
  end

  // Command selection: refresh work first, then the buffered request.
  always_comb begin
    sel_kind = CMD_NOP;
    sel_bank = '0;
    sel_addr = '0;
    sel_ap   = 1'b0;
    if (ref_pending) begin
      if (all_idle && rfc_done) begin
        sel_kind = CMD_REF;
      end else if (pre_hit) begin
        sel_kind = CMD_PRE;
        sel_bank = pre_sel;
      end
    end else if (buf_full) begin
      sel_bank = buf_bank;
      if (bank_open[buf_bank]) begin
        if (bank_rcd_done[buf_bank]) begin
          if (bank_row[buf_bank] == buf_row) begin
            sel_kind = buf_wr ? CMD_WR : CMD_RD;
            sel_addr = ROW_W'(buf_col);
            sel_ap   = buf_ap;
          end else begin
            sel_kind = CMD_PRE;
          end
        end
      end else if (bank_act_ok[buf_bank] && rfc_done) begin
        sel_kind = CMD_ACT;
        sel_addr = buf_row;
      end
    end
  end

  assign cmd_valid   = (sel_kind != CMD_NOP);
  assign cmd_kind    = sel_kind;
  assign cmd_bank    = sel_bank;
  assign cmd_addr    = sel_addr;
  assign cmd_autopre = sel_ap;

  AST_NO_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RCD > 1 && sel_kind == CMD_ACT) |=>
      !(col_fire && sel_bank == $past(sel_bank))); // R4
  AST_NO_ACT_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RFC > 1 && sel_kind == CMD_REF) |=> (sel_kind != CMD_ACT)); // R7
  AST_ONE_BANK_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_v | col_v | pre_v)); // R8

endmodule

// File: tb/sdram_cmd_sched_tb.sv
`timescale 1ns/1ps
module sdram_cmd_sched_tb;

  localparam int NB     = 4;
  localparam int RCD    = 3;
  localparam int RP     = 3;
  localparam int RC     = 11;
  localparam int RFC    = 10;
  localparam int RINT   = 150;
  localparam int NREQ   = 170;
  localparam int LIMIT  = 40000;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_autopre;
  logic [1:0]  req_bank;
  logic [12:0] req_row;
  logic [9:0]  req_col;
  logic        cmd_valid, cmd_autopre;
  logic [2:0]  cmd_kind;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;

  sdram_cmd_sched #(
    .NUM_BANKS(NB), .ROW_W(13), .COL_W(10), .T_RCD(RCD), .T_RP(RP),
    .T_RC(RC), .T_RFC(RFC), .REF_INTERVAL(RINT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_autopre(req_autopre), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_autopre(cmd_autopre)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // stimulus list
  int s_wr[NREQ], s_ap[NREQ], s_bk[NREQ], s_row[NREQ], s_col[NREQ], s_gap[NREQ];

  // behavioural model state (absolute cycle numbers)
  int  m_open[NB], m_row[NB], m_colok[NB], m_actok[NB], m_rpok[NB];
  int  m_refok;
  bit  m_pend;
  bit  m_bfull, m_bwr, m_bap;
  int  m_bbk, m_brow, m_bcol;
  int  n_act_exp, n_act_obs, n_ref_exp, n_ref_obs;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_req(input int i, input int wr, input int ap, input int bk,
                         input int row, input int col, input int gap);
    s_wr[i] = wr; s_ap[i] = ap; s_bk[i] = bk;
    s_row[i] = row; s_col[i] = col; s_gap[i] = gap;
  endtask

  initial begin
    int c, idx, gapc, drain;
    bit off, done;
    int e_kind, e_bank, e_addr, e_ap;
    bit e_ready, allidle, found, other_busy;
    string tag;

    set_req(0, 0, 0, 0, 5,    1,    0);
    set_req(1, 0, 0, 0, 5,    2,    0);
    set_req(2, 0, 0, 0, 5,    3,    0);
    set_req(3, 1, 0, 1, 7,    4,    0);
    set_req(4, 0, 0, 0, 9,    5,    0);
    set_req(5, 0, 1, 2, 1,    6,    0);
    set_req(6, 0, 0, 2, 1,    7,    0);
    set_req(7, 1, 1, 3, 8191, 1023, 0);
    set_req(8, 1, 0, 1, 7,    0,    2);
    set_req(9, 0, 0, 0, 9,    8,    0);
    for (int i = 10; i < NREQ; i++)
      set_req(i, $urandom_range(0, 1), ($urandom_range(0, 3) == 0) ? 1 : 0,
              $urandom_range(0, 3), $urandom_range(0, 2),
              $urandom_range(0, 1023), $urandom_range(0, 3));

    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_colok[b] = 0; m_actok[b] = 0; m_rpok[b] = 0;
    end
    m_refok = 0; m_pend = 0; m_bfull = 0; m_bwr = 0; m_bap = 0;
    m_bbk = 0; m_brow = 0; m_bcol = 0;
    n_act_exp = 0; n_act_obs = 0; n_ref_exp = 0; n_ref_obs = 0;

    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_autopre = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0;
    repeat (3) begin
      @(negedge clk);
      check(cmd_valid === 1'b0, "R1", "cmd_valid in reset", int'(cmd_valid), 0);
      check(req_ready === 1'b1, "R1", "req_ready in reset", int'(req_ready), 1);
    end
    rst_n = 1'b1;

    c = 0; idx = 0; gapc = s_gap[0]; off = 0; done = 0; drain = 0;
    while (!done) begin
      // drive the request port
      if (!off && idx < NREQ) begin
        if (gapc == 0) off = 1;
        else gapc--;
      end
      req_valid = off;
      if (off) begin
        req_write = s_wr[idx][0]; req_autopre = s_ap[idx][0];
        req_bank = 2'(s_bk[idx]); req_row = 13'(s_row[idx]); req_col = 10'(s_col[idx]);
      end

      // expected command for this cycle
      e_kind = 0; e_bank = 0; e_addr = 0; e_ap = 0;
      if (m_pend) begin
        allidle = 1;
        for (int b = 0; b < NB; b++)
          if (m_open[b] != 0 || c < m_rpok[b]) allidle = 0;
        if (allidle && c >= m_refok) e_kind = 5;
        else begin
          found = 0;
          for (int b = 0; b < NB; b++)
            if (!found && m_open[b] != 0 && c >= m_colok[b]) begin
              found = 1; e_kind = 4; e_bank = b;
            end
        end
      end else if (m_bfull) begin
        e_bank = m_bbk;
        if (m_open[m_bbk] != 0) begin
          if (c >= m_colok[m_bbk]) begin
            if (m_row[m_bbk] == m_brow) begin
              e_kind = m_bwr ? 3 : 2; e_addr = m_bcol; e_ap = m_bap;
            end else e_kind = 4;
          end
        end else if (c >= m_rpok[m_bbk] && c >= m_actok[m_bbk] && c >= m_refok) begin
          e_kind = 1; e_addr = m_brow;
        end
      end
      e_ready = !m_bfull || e_kind == 2 || e_kind == 3;

      // requirement tag for this comparison
      other_busy = 0;
      for (int b = 0; b < NB; b++)
        if (b != e_bank && (c < m_actok[b] || c < m_colok[b] || c < m_rpok[b])) other_busy = 1;
      case (e_kind)
        1: tag = other_busy ? "R9" : "R3";
        2, 3: tag = (e_ap != 0) ? "R6" : (other_busy ? "R9" : "R4");
        4: tag = m_pend ? "R7" : "R5";
        5: tag = "R7";
        default: tag = m_pend ? "R7" : "R3";
      endcase

      check(int'(cmd_kind) == e_kind, tag, "cmd_kind", int'(cmd_kind), e_kind);
      if (e_kind != 0) begin
        check(int'(cmd_bank) == e_bank, tag, "cmd_bank", int'(cmd_bank), e_bank);
        check(int'(cmd_addr) == e_addr, tag, "cmd_addr", int'(cmd_addr), e_addr);
        check(int'(cmd_autopre) == e_ap, tag, "cmd_autopre", int'(cmd_autopre), e_ap);
      end
      check(cmd_valid === (cmd_kind != 3'd0), "R8", "cmd_valid vs kind",
            int'(cmd_valid), int'(cmd_kind != 3'd0));
      check(req_ready === e_ready, (c == 0) ? "R1" : "R2", "req_ready",
            int'(req_ready), int'(e_ready));
      if (cmd_valid && cmd_kind == 3'd1) n_act_obs++;
      if (cmd_valid && cmd_kind == 3'd5) n_ref_obs++;

      // model update for the coming edge
      case (e_kind)
        1: begin
          m_open[e_bank] = 1; m_row[e_bank] = e_addr;
          m_colok[e_bank] = c + RCD; m_actok[e_bank] = c + RC; n_act_exp++;
        end
        2, 3: begin
          m_bfull = 0;
          if (e_ap != 0) begin m_open[e_bank] = 0; m_rpok[e_bank] = c + RP; end
        end
        4: begin m_open[e_bank] = 0; m_rpok[e_bank] = c + RP; end
        5: begin m_pend = 0; m_refok = c + RFC; n_ref_exp++; end
        default: ;
      endcase
      if (((c + 1) % RINT) == 0) m_pend = 1;
      if (off && e_ready) begin
        m_bfull = 1; m_bwr = s_wr[idx][0]; m_bap = s_ap[idx][0];
        m_bbk = s_bk[idx]; m_brow = s_row[idx]; m_bcol = s_col[idx];
        off = 0; idx++;
        if (idx < NREQ) gapc = s_gap[idx];
      end

      @(negedge clk);
      c++;
      if (idx == NREQ && !m_bfull && !off) drain++;
      if (drain > 2 * RINT) done = 1;
      if (c > LIMIT) begin
        check(1'b0, "R2", "watchdog expired", c, LIMIT);
        done = 1;
      end
    end

    check(n_act_obs == n_act_exp, "R4", "ACTIVE count (hits skip ACTIVE)", n_act_obs, n_act_exp);
    check(n_ref_obs == n_ref_exp && n_ref_exp > 2, "R7", "REFRESH count", n_ref_obs, n_ref_exp);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule